// File: doc/BRIEF.md
# Down-Counting Timer with Repetition Gate

This block is a 16-bit timer that counts down from a programmable reload value to zero, one step per prescaled tick, then wraps back to the reload value and keeps counting. A programmable divider sets how many timer clocks make one tick. A repetition counter lets several underflows pass before one update event is raised. Software can also force an update event through a dedicated register bit. A control bit blocks all update events.

The divider, reload and repetition settings are written into holding registers. They are copied into the working registers only when an update event fires, so a new setting never cuts a running period short. Each update event sets a sticky flag. Software clears the flag, and an optional interrupt output follows it. Software reaches the block through a simple single-cycle write port and a combinational read port.

Top module: `dtr_timer`

## Requirements
- R1: While running, each tick lowers the counter by one. A tick that finds the counter at 0 reloads it: with the working reload value when no update fires, and with the held reload value when an update fires.
- R2: A tick occurs once every DIV+1 timer clocks while running, where DIV is the working divider value. DIV=0 gives a tick on every clock.
- R3: An update event fires on every (REPS+1)-th underflow, where REPS is the working repetition value. With REPS=0, every underflow fires one.
- R4: Writing 1 to bit 0 of address 2 loads the counter with the held reload value on that clock edge and fires an update event. The bit reads back as 0.
- R5: While control bit 1 is set, no update event fires, from either underflow or software. The update pulse, the flag and the working registers stay untouched.
- R6: The working divider, reload and repetition values change only on an update event, when they take the held values. A held value written in mid-period does not alter the running period.
- R7: The flag (status bit 0 at address 1) is set by every update event. It is cleared only by writing status bit 0 as 0. Writing 1 leaves it unchanged, and a set takes priority over a clear in the same cycle.
- R8: irq_o is high exactly while the flag is set and control bit 8 is 1.
- R9: While control bit 0 is 0, the counter and the divider phase hold their values.
- R10: Control bit 4 (direction) always reads as 1. Only counting down is supported.
- R11: Address map: 0 control (bit 0 run, bit 1 update block, bit 4 direction, bit 8 interrupt enable), 1 status, 2 event-generate, 3 counter (read-only), 4 divider, 5 reload, 6 repetition. After reset every register reads 0 except the direction bit.
- R12: upd_o pulses high for one clock, in the cycle after the edge on which an update event is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe, taken on the rising edge |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| count_o | output | 16 | Current counter value |
| upd_o | output | 1 | One-cycle pulse after each update event |
| uif_o | output | 1 | Sticky update flag |
| irq_o | output | 1 | Update interrupt request |

## Verification
A wrong working register or a wrong repetition count does not show at once. It shows at the next underflow, as a counter value that wraps to the wrong number or as an upd_o pulse that is missing or comes extra. It can therefore stay hidden for up to (REPS+1)·(TOP+1)·(DIV+1) clocks. The bench runs long enough to pass several such periods, and compares the final counter value and the number of update pulses with closed-form values. A wrong divider phase shifts every later tick, so it shows as a counter value that is off by one or more at the sampling point.

// File: rtl/dtr_pkg.sv
package dtr_pkg;

  typedef enum logic [2:0] {
    A_CTRL  = 3'd0,
    A_STAT  = 3'd1,
    A_EVGEN = 3'd2,
    A_COUNT = 3'd3,
    A_DIV   = 3'd4,
    A_TOP   = 3'd5,
    A_REPS  = 3'd6
  } reg_addr_e;

  localparam int CTRL_RUN  = 0;
  localparam int CTRL_HOLD = 1;
  localparam int CTRL_DIR  = 4;
  localparam int CTRL_UIE  = 8;

  typedef struct packed {
    logic uie;
    logic hold_upd;
    logic run;
  } ctrl_t;

endpackage

// File: rtl/dtr_regs.sv
module dtr_regs
  import dtr_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  input  logic          uev,
  input  logic [W-1:0]  cnt,
  output ctrl_t         ctrl,
  output logic          sw_gen,
  output logic          uif,
  output logic [W-1:0]  div_act,
  output logic [W-1:0]  top_act,
  output logic [W-1:0]  top_pre,
  output logic [W-1:0]  reps_act,
  output logic [W-1:0]  reps_pre
);

  ctrl_t        ctrl_q, ctrl_d;
  logic         uif_q, uif_d;
  logic [W-1:0] div_pre_q, div_pre_d;
  logic [W-1:0] top_pre_q, top_pre_d;
  logic [W-1:0] reps_pre_q, reps_pre_d;
  logic [W-1:0] div_act_q, div_act_d;
  logic [W-1:0] top_act_q, top_act_d;
  logic [W-1:0] reps_act_q, reps_act_d;
  logic         hit_ctrl, hit_stat, hit_evgen, hit_div, hit_top, hit_reps;
  logic         flag_clr;

  // write decode
  always_comb begin
    hit_ctrl  = wr_en && (wr_addr == AW'(A_CTRL));
    hit_stat  = wr_en && (wr_addr == AW'(A_STAT));
    hit_evgen = wr_en && (wr_addr == AW'(A_EVGEN));
    hit_div   = wr_en && (wr_addr == AW'(A_DIV));
    hit_top   = wr_en && (wr_addr == AW'(A_TOP));
    hit_reps  = wr_en && (wr_addr == AW'(A_REPS));
    sw_gen    = hit_evgen && wr_data[0];
    flag_clr  = hit_stat && !wr_data[0];
  end

  // next state
  always_comb begin
    ctrl_d     = ctrl_q;
    uif_d      = uif_q;
    div_pre_d  = div_pre_q;
    top_pre_d  = top_pre_q;
    reps_pre_d = reps_pre_q;
    div_act_d  = div_act_q;
    top_act_d  = top_act_q;
    reps_act_d = reps_act_q;
    if (hit_ctrl) begin
      ctrl_d.run      = wr_data[CTRL_RUN];
      ctrl_d.hold_upd = wr_data[CTRL_HOLD];
      ctrl_d.uie      = wr_data[CTRL_UIE];
    end
    // hardware set wins over software clear
    if (uev)           uif_d = 1'b1;
    else if (flag_clr) uif_d = 1'b0;
    if (hit_div)  div_pre_d  = wr_data;
    if (hit_top)  top_pre_d  = wr_data;
    if (hit_reps) reps_pre_d = wr_data;
    if (uev) begin
      div_act_d  = div_pre_q;
      top_act_d  = top_pre_q;
      reps_act_d = reps_pre_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      uif_q      <= 1'b0;
      div_pre_q  <= '0;
      top_pre_q  <= '0;
      reps_pre_q <= '0;
      div_act_q  <= '0;
      top_act_q  <= '0;
      reps_act_q <= '0;
    end else begin
      ctrl_q     <= ctrl_d;
      uif_q      <= uif_d;
      div_pre_q  <= div_pre_d;
      top_pre_q  <= top_pre_d;
      reps_pre_q <= reps_pre_d;
      div_act_q  <= div_act_d;
      top_act_q  <= top_act_d;
      reps_act_q <= reps_act_d;
    end
  end

  // read mux
  always_comb begin
    rd_data = '0;
    case (rd_addr)
      AW'(A_CTRL): begin
        rd_data[CTRL_RUN]  = ctrl_q.run;
        rd_data[CTRL_HOLD] = ctrl_q.hold_upd;
        rd_data[CTRL_DIR]  = 1'b1;
        rd_data[CTRL_UIE]  = ctrl_q.uie;
      end
      AW'(A_STAT):  rd_data[0] = uif_q;
      AW'(A_COUNT): rd_data = cnt;
      AW'(A_DIV):   rd_data = div_pre_q;
      AW'(A_TOP):   rd_data = top_pre_q;
      AW'(A_REPS):  rd_data = reps_pre_q;
      default:      rd_data = '0;
    endcase
  end

  assign ctrl     = ctrl_q;
  assign uif      = uif_q;
  assign div_act  = div_act_q;
  assign top_act  = top_act_q;
  assign top_pre  = top_pre_q;
  assign reps_act = reps_act_q;
  assign reps_pre = reps_pre_q;

  assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !uev |=> ($stable(div_act_q) && $stable(top_act_q) && $stable(reps_act_q)));

  assert_flag_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uif_q) |-> $past(uev));

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (uif_q && !flag_clr) |=> uif_q);

  assert_dir_reads_one_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == AW'(A_CTRL)) |-> rd_data[CTRL_DIR]);

endmodule

// File: rtl/dtr_prescale.sv
module dtr_prescale #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         restart,
  input  logic [W-1:0] div,
  output logic         tick
);

  logic [W-1:0] pc_q, pc_d;

  always_comb begin
    tick = run && (pc_q == div);
    pc_d = pc_q;
    if (restart)  pc_d = '0;
    else if (run) pc_d = tick ? '0 : pc_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart) |=> (!tick || (div == '0)));

  assert_phase_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> $stable(pc_q));

endmodule

// File: rtl/dtr_count.sv
module dtr_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         sw_gen,
  input  logic         hold_upd,
  input  logic [W-1:0] top_act,
  input  logic [W-1:0] top_pre,
  input  logic [W-1:0] reps_act,
  input  logic [W-1:0] reps_pre,
  output logic [W-1:0] cnt,
  output logic         uev
);

  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] rep_q, rep_d;
  logic         wrap, gen_ok;

  always_comb begin
    wrap   = tick && (cnt_q == '0);
    gen_ok = sw_gen && !hold_upd;
    uev    = !hold_upd && (sw_gen || (wrap && (rep_q == '0)));
    cnt_d  = cnt_q;
    rep_d  = rep_q;
    if (gen_ok) begin
      cnt_d = top_pre;
      rep_d = reps_pre;
    end else if (wrap) begin
      cnt_d = uev ? top_pre : top_act;
      if (uev)               rep_d = reps_pre;
      else if (rep_q == '0)  rep_d = reps_act;
      else                   rep_d = rep_q - W'(1);
    end else if (tick) begin
      cnt_d = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rep_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      rep_q <= rep_d;
    end
  end

  assign cnt = cnt_q;

  assert_step_down_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (cnt_q != '0) && !(sw_gen && !hold_upd)) |=> (cnt_q == $past(cnt_q) - W'(1)));

  assert_wrap_reload_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (cnt_q == '0) && !uev) |=> (cnt_q == $past(top_act)));

  assert_count_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !(sw_gen && !hold_upd)) |=> $stable(cnt_q));

endmodule

// File: rtl/dtr_timer.sv
module dtr_timer
  import dtr_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  output logic [W-1:0]  count_o,
  output logic          upd_o,
  output logic          uif_o,
  output logic          irq_o
);

  logic         rs_meta_q, rs_q;
  logic         srst_n;
  ctrl_t        ctrl;
  logic         sw_gen, uif, uev, tick;
  logic [W-1:0] div_act, top_act, top_pre, reps_act, reps_pre, cnt;
  logic         upd_q;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      rs_q      <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rs_q      <= rs_meta_q;
    end
  end
  assign srst_n = rs_q;

  dtr_regs #(.W(W), .AW(AW)) u_regs (
    .clk      (clk),
    .rst_n    (srst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .uev      (uev),
    .cnt      (cnt),
    .ctrl     (ctrl),
    .sw_gen   (sw_gen),
    .uif      (uif),
    .div_act  (div_act),
    .top_act  (top_act),
    .top_pre  (top_pre),
    .reps_act (reps_act),
    .reps_pre (reps_pre)
  );

  dtr_prescale #(.W(W)) u_presc (
    .clk     (clk),
    .rst_n   (srst_n),
    .run     (ctrl.run),
    .restart (uev),
    .div     (div_act),
    .tick    (tick)
  );

  dtr_count #(.W(W)) u_count (
    .clk      (clk),
    .rst_n    (srst_n),
    .tick     (tick),
    .sw_gen   (sw_gen),
    .hold_upd (ctrl.hold_upd),
    .top_act  (top_act),
    .top_pre  (top_pre),
    .reps_act (reps_act),
    .reps_pre (reps_pre),
    .cnt      (cnt),
    .uev      (uev)
  );

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) upd_q <= 1'b0;
    else         upd_q <= uev;
  end

  assign count_o = cnt;
  assign upd_o   = upd_q;
  assign uif_o   = uif;
  assign irq_o   = uif && ctrl.uie;

  assert_block_upd_R5: assert property (@(posedge clk) disable iff (!srst_n)
    ctrl.hold_upd |=> !upd_o);

  assert_sw_load_R4: assert property (@(posedge clk) disable iff (!srst_n)
    (sw_gen && !ctrl.hold_upd) |=> ((count_o == $past(top_pre)) && upd_o));

  assert_irq_flag_R8: assert property (@(posedge clk) disable iff (!srst_n)
    irq_o |-> uif_o);

  assert_pulse_single_R12: assert property (@(posedge clk) disable iff (!srst_n)
    upd_o |-> $past(uev));

endmodule

// File: tb/test_dtr_timer.sv
`timescale 1ns/1ps
module test_dtr_timer;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic [2:0]  rd_addr;
  logic [15:0] rd_data;
  logic [15:0] count_o;
  logic        upd_o, uif_o, irq_o;

  int total = 0;
  int bad   = 0;

  dtr_timer i_dtr_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .count_o(count_o), .upd_o(upd_o),
    .uif_o(uif_o), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  localparam logic [2:0] CTRL = 3'd0, STAT = 3'd1, EVGEN = 3'd2, COUNT = 3'd3,
                         DIVR = 3'd4, TOPR = 3'd5, REPR = 3'd6;

  // div, top, reps, edges, expected count, expected update pulses
  localparam logic [15:0] VEC [0:5][0:5] = '{
    '{16'd0, 16'd5,  16'd0, 16'd20,  16'd3,  16'd3},
    '{16'd1, 16'd3,  16'd0, 16'd17,  16'd3,  16'd2},
    '{16'd0, 16'd4,  16'd2, 16'd31,  16'd3,  16'd2},
    '{16'd2, 16'd0,  16'd1, 16'd12,  16'd0,  16'd2},
    '{16'd3, 16'd9,  16'd0, 16'd8,   16'd7,  16'd0},
    '{16'd0, 16'd99, 16'd0, 16'd100, 16'd99, 16'd1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the following posedge
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic run(input int n, output int ups);
    ups = 0;
    repeat (n) begin
      @(negedge clk);
      if (upd_o) ups++;
    end
  endtask

  initial begin
    #4000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] r;
    logic [15:0] held;
    int ups;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state (R11, R10)
    rd(COUNT, r); chk("R11 count after reset", r, 16'h0);
    rd(STAT, r);  chk("R11 status after reset", r, 16'h0);
    rd(TOPR, r);  chk("R11 reload after reset", r, 16'h0);
    rd(CTRL, r);  chk("R10 ctrl after reset", r, 16'h0010);
    chk("R8 irq after reset", irq_o, 1'b0);
    wr(CTRL, 16'h0000);
    rd(CTRL, r);  chk("R10 dir bit after writing 0", r[4], 1'b1);

    // table walk (R1 R2 R3 R6 R7 R12)
    for (int i = 0; i < 6; i++) begin
      wr(CTRL, 16'h0000);
      wr(DIVR, VEC[i][0]);
      wr(TOPR, VEC[i][1]);
      wr(REPR, VEC[i][2]);
      wr(EVGEN, 16'h0001);
      wr(STAT, 16'h0000);
      wr(CTRL, 16'h0001);
      run(int'(VEC[i][3]), ups);
      chk($sformatf("R1 R2 row %0d count", i), count_o, VEC[i][4]);
      chk($sformatf("R3 R12 row %0d update pulses", i), ups, VEC[i][5]);
      chk($sformatf("R7 row %0d flag", i), uif_o, (VEC[i][5] != 0));
    end

    // R9: run bit cleared holds the counter
    wr(CTRL, 16'h0000);
    held = count_o;
    repeat (5) @(negedge clk);
    chk("R9 counter held while stopped", count_o, held);

    // R4: software generate
    wr(TOPR, 16'd7);
    wr(EVGEN, 16'h0001);
    chk("R4 counter loaded", count_o, 16'd7);
    chk("R4 R12 update pulse", upd_o, 1'b1);
    chk("R4 flag set", uif_o, 1'b1);
    rd(EVGEN, r); chk("R4 generate bit self-clears", r, 16'h0);

    // R7: only a 0 clears the flag
    wr(STAT, 16'h0001);
    chk("R7 write 1 keeps flag", uif_o, 1'b1);
    chk("R12 pulse lasts one cycle", upd_o, 1'b0);
    wr(STAT, 16'h0000);
    chk("R7 write 0 clears flag", uif_o, 1'b0);

    // R8: interrupt gating
    wr(EVGEN, 16'h0001);
    wr(CTRL, 16'h0100);
    chk("R8 irq with enable", irq_o, 1'b1);
    wr(CTRL, 16'h0000);
    chk("R8 irq without enable", irq_o, 1'b0);
    wr(STAT, 16'h0000);

    // R5: update block
    wr(CTRL, 16'h0002);
    wr(TOPR, 16'd3);
    wr(EVGEN, 16'h0001);
    chk("R5 generate blocked count", count_o, 16'd7);
    chk("R5 generate blocked pulse", upd_o, 1'b0);
    chk("R5 generate blocked flag", uif_o, 1'b0);
    wr(CTRL, 16'h0003);
    run(20, ups);
    chk("R5 no underflow updates", ups, 0);
    chk("R5 R6 old reload kept", count_o, 16'd3);
    chk("R5 flag stays clear", uif_o, 1'b0);

    // R6: mid-period reload write waits for an update
    wr(CTRL, 16'h0000);
    wr(DIVR, 16'd0);
    wr(TOPR, 16'd5);
    wr(REPR, 16'd1);
    wr(EVGEN, 16'h0001);
    wr(STAT, 16'h0000);
    wr(TOPR, 16'd2);
    wr(CTRL, 16'h0001);
    run(6, ups);
    chk("R6 first wrap uses working reload", count_o, 16'd5);
    chk("R3 no update on first underflow", ups, 0);
    run(6, ups);
    chk("R6 update wrap uses held reload", count_o, 16'd2);
    chk("R3 update on second underflow", ups, 1);
    chk("R7 flag after repetition update", uif_o, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule